// File: doc/BRIEF.md
# Linked-List Receive Buffer Queue Manager

This block keeps track of a ring of cell buffers that live in shared memory and are chained together by link words. It holds three pointers into that chain. The collect pointer marks the oldest buffer that is full and waiting for the processor. The head pointer marks the buffer that the next incoming cell will fill. The tail pointer marks the last free buffer. Buffers from collect up to head are ready for software. Buffers from head up to tail are free. When head catches up with tail, no free buffer is left.

Each buffer starts at its pointer value. Word `ptr + TS_OFS` (offset 0 by default) receives a timestamp word. Word `ptr + LINK_OFS` (offset 1 by default) holds the pointer of the next buffer in the chain. When a cell completes, the block first writes the timestamp through a valid/ready write port. It then fetches the link through a valid/ready read port and moves head onto the returned pointer. Link reads have a request side (`mr_valid`/`mr_ready`) and a response side. On the response side a single-cycle `mrsp_valid` always accepts the data, because the block never has more than one read outstanding. A request, once raised, keeps its address (and, for writes, its data) unchanged until the matching ready is seen. This means the memory may apply back-pressure for any number of cycles.

Software reaches the pointers, a status word and a command strobe through a small register port. It can read the collect pointer with an advance option so that one access both picks up a buffer and steps to the next one. A local agent other than the receiver can also be handed a free buffer through a command strobe.

Top module: `rcq_mgr`

## Requirements
- R1: After reset, all three pointers read 0, `irq_empty` is 1, the status word reads 2, `rx_start_ready` is 1, and neither memory port raises valid.
- R2: Register writes at address 0 (collect), 1 (head) and 2 (tail) replace that pointer with `reg_wdata`, with no sanity check. A read at the same address returns the value written.
- R3: A read at address 0 with `reg_adv` set returns the current collect pointer and moves collect to the link word of that buffer. If collect equals head at that read, collect stays where it is.
- R4: When a non-discarded cell's `rx_done` arrives, the block first writes a timestamp word to `head + TS_OFS`. It then reads `head + LINK_OFS`, and head takes the returned pointer.
- R5: The timestamp word has bit DW-1 set to 1 and bit DW-2 set to the source (1 for an agent buffer, 0 for a received cell). Its low DW-2 bits hold the number of whole FRAME-cycle periods since reset, sampled in the cycle the cell's `rx_done` is accepted.
- R6: `irq_empty` is 1 exactly when head equals tail.
- R7: A cell accepted while the free queue is empty drives `rx_discard` high until its `rx_done`. It makes no memory access and leaves head unchanged. It also sets the sticky `tog_flag`.
- R8: A read at address 3 returns the status word: bit 2 is agent request pending, bit 1 is empty, bit 0 is the sticky discard flag. The same read clears the sticky flag.
- R9: A write at address 3 with bit 0 set posts an agent request. Command bits are not stored. A further request while one is pending is ignored. A pending request produces exactly one timestamped buffer (source 1), one `agent_grant` pulse with `agent_buf` equal to the buffer taken, and a head advance.
- R10: `rx_start_ready` is high only while the receiver is idle waiting for a start of cell. It is held low while an agent request is pending and the free queue is not empty. A pending request is not serviced while the queue is empty.
- R11: Each memory request holds valid, address and data stable until ready. At most one link read is outstanding at a time.
- R12: When a head link fetch and a collect link fetch are both waiting for the idle read port, the head fetch is issued first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_adv | input | 1 | With a read at address 0: step collect to the next buffer |
| reg_addr | input | 2 | 0 collect, 1 head, 2 tail, 3 status/command |
| reg_wdata | input | AW | Write data; at address 3, bit 0 requests an agent buffer |
| reg_rdata | output | AW | Read data, valid in the cycle of the read |
| rx_start_valid | input | 1 | Receiver offers a new cell |
| rx_start_ready | output | 1 | Block accepts the cell start |
| rx_done | input | 1 | Current cell has been fully received |
| rx_buf | output | AW | Buffer the current cell goes into (head) |
| rx_discard | output | 1 | Current cell is drained and thrown away |
| agent_grant | output | 1 | One-cycle pulse: agent buffer handed out |
| agent_buf | output | AW | Buffer handed to the agent, valid with the grant |
| irq_empty | output | 1 | Free queue empty interrupt |
| tog_flag | output | 1 | Sticky: a cell was discarded |
| mr_valid | output | 1 | Link read request valid |
| mr_ready | input | 1 | Memory accepts the read request |
| mr_addr | output | AW | Link read word address |
| mrsp_valid | input | 1 | Link read data valid |
| mrsp_data | input | AW | Pointer field of the link word |
| mw_valid | output | 1 | Timestamp write valid |
| mw_ready | input | 1 | Memory accepts the write |
| mw_addr | output | AW | Timestamp write word address |
| mw_data | output | DW | Timestamp word |

## Verification
The hardest state to reach from the ports is the one where the head link fetch and a collect-advance fetch both want the idle read port in the same cycle (R12). To get there, the bench holds the write port's ready low, so a finished cell waits in its timestamp write. It then releases that ready in the same cycle as it issues an advancing read of collect. The two fetch requests therefore rise together, and the order of the read addresses on the port shows which one won. The empty-queue paths are reached by sweeping the tail across several distances and then running cells until one is discarded.

// File: rtl/rcq_pkg.sv
package rcq_pkg;
  typedef enum logic [2:0] {F_IDLE, F_RECV, F_DROP, F_STAMP, F_FETCH} fill_st_t;
  typedef enum logic [1:0] {A_IDLE, A_OFFER, A_WAIT} arb_st_t;
  localparam logic [1:0] RA_COLLECT = 2'd0;
  localparam logic [1:0] RA_HEAD    = 2'd1;
  localparam logic [1:0] RA_TAIL    = 2'd2;
  localparam logic [1:0] RA_CTRL    = 2'd3;
  localparam int CMD_AGENT = 0;
endpackage

// File: rtl/rcq_stamp.sv
module rcq_stamp #(
  parameter int DW    = 16,
  parameter int FRAME = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [DW-3:0] frame_cnt
);
  localparam int PW = (FRAME > 2) ? $clog2(FRAME) : 1;
  localparam logic [PW-1:0] PLAST = PW'(FRAME - 1);

  logic [PW-1:0] pre;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre       <= '0;
      frame_cnt <= '0;
    end else if (pre == PLAST) begin
      pre       <= '0;
      frame_cnt <= frame_cnt + 1'b1;
    end else begin
      pre <= pre + 1'b1;
    end
  end
endmodule

// File: rtl/rcq_arb.sv
module rcq_arb #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          h_req,
  input  logic [AW-1:0] h_addr,
  input  logic          c_req,
  input  logic [AW-1:0] c_addr,
  output logic          mr_valid,
  input  logic          mr_ready,
  output logic [AW-1:0] mr_addr,
  input  logic          mrsp_valid,
  output logic          h_rsp,
  output logic          c_rsp
);
  import rcq_pkg::*;

  arb_st_t       st;
  logic          own_head;
  logic [AW-1:0] addr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= A_IDLE;
      own_head <= 1'b0;
      addr_q   <= '0;
    end else begin
      case (st)
        A_IDLE: begin
          if (h_req) begin
            own_head <= 1'b1;
            addr_q   <= h_addr;
            st       <= A_OFFER;
          end else if (c_req) begin
            own_head <= 1'b0;
            addr_q   <= c_addr;
            st       <= A_OFFER;
          end
        end
        A_OFFER: if (mr_ready) st <= A_WAIT;
        A_WAIT:  if (mrsp_valid) st <= A_IDLE;
        default: st <= A_IDLE;
      endcase
    end
  end

  assign mr_valid = (st == A_OFFER);
  assign mr_addr  = addr_q;
  assign h_rsp    = (st == A_WAIT) && mrsp_valid && own_head;
  assign c_rsp    = (st == A_WAIT) && mrsp_valid && !own_head;

  a_r11_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mr_valid && !mr_ready |=> mr_valid && $stable(mr_addr));
  a_r11_single_read: assert property (@(posedge clk) disable iff (!rst_n)
    mrsp_valid |-> st == A_WAIT);
  a_r12_head_first: assert property (@(posedge clk) disable iff (!rst_n)
    (st == A_IDLE) && h_req && c_req |=> mr_valid && mr_addr == $past(h_addr));
endmodule

// File: rtl/rcq_fill.sv
module rcq_fill #(
  parameter int AW       = 8,
  parameter int DW       = 16,
  parameter int TS_OFS   = 0,
  parameter int LINK_OFS = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] head,
  input  logic          empty,
  input  logic          pending,
  input  logic [DW-3:0] frame_cnt,
  input  logic          rx_start_valid,
  output logic          rx_start_ready,
  input  logic          rx_done,
  output logic          rx_discard,
  output logic          mw_valid,
  input  logic          mw_ready,
  output logic [AW-1:0] mw_addr,
  output logic [DW-1:0] mw_data,
  output logic          h_req,
  output logic [AW-1:0] h_addr,
  input  logic          h_rsp,
  input  logic [AW-1:0] rsp_ptr,
  output logic          head_load,
  output logic [AW-1:0] head_next,
  output logic          agent_grant,
  output logic [AW-1:0] agent_buf,
  output logic          tog_set
);
  import rcq_pkg::*;

  localparam logic [AW-1:0] TSO = AW'(TS_OFS);
  localparam logic [AW-1:0] LKO = AW'(LINK_OFS);

  fill_st_t      st;
  logic [AW-1:0] cur;
  logic          src_agent;
  logic [DW-1:0] word;
  logic          accept;
  logic          serve;

  assign serve          = (st == F_IDLE) && pending && !empty;
  assign rx_start_ready = (st == F_IDLE) && !(pending && !empty);
  assign accept         = rx_start_valid && rx_start_ready;
  assign tog_set        = accept && empty;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= F_IDLE;
      cur       <= '0;
      src_agent <= 1'b0;
      word      <= '0;
    end else begin
      case (st)
        F_IDLE: begin
          if (serve) begin
            cur       <= head;
            src_agent <= 1'b1;
            word      <= {1'b1, 1'b1, frame_cnt};
            st        <= F_STAMP;
          end else if (accept) begin
            cur       <= head;
            src_agent <= 1'b0;
            st        <= empty ? F_DROP : F_RECV;
          end
        end
        F_RECV: if (rx_done) begin
          word <= {1'b1, 1'b0, frame_cnt};
          st   <= F_STAMP;
        end
        F_DROP:  if (rx_done) st <= F_IDLE;
        F_STAMP: if (mw_ready) st <= F_FETCH;
        F_FETCH: if (h_rsp) st <= F_IDLE;
        default: st <= F_IDLE;
      endcase
    end
  end

  assign rx_discard  = (st == F_DROP);
  assign mw_valid    = (st == F_STAMP);
  assign mw_addr     = cur + TSO;
  assign mw_data     = word;
  assign h_req       = (st == F_FETCH);
  assign h_addr      = cur + LKO;
  assign head_load   = (st == F_FETCH) && h_rsp;
  assign head_next   = rsp_ptr;
  assign agent_grant = head_load && src_agent;
  assign agent_buf   = cur;

  a_r11_wr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mw_valid && !mw_ready |=> mw_valid && $stable(mw_addr) && $stable(mw_data));
  a_r7_drop_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
    rx_start_valid && rx_start_ready && empty |=> rx_discard && !mw_valid);
  a_r5_stamp_marker: assert property (@(posedge clk) disable iff (!rst_n)
    mw_valid |-> mw_data[DW-1]);
endmodule

// File: rtl/rcq_mgr.sv
module rcq_mgr #(
  parameter int AW       = 8,
  parameter int DW       = 16,
  parameter int FRAME    = 64,
  parameter int TS_OFS   = 0,
  parameter int LINK_OFS = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic          reg_adv,
  input  logic [1:0]    reg_addr,
  input  logic [AW-1:0] reg_wdata,
  output logic [AW-1:0] reg_rdata,
  input  logic          rx_start_valid,
  output logic          rx_start_ready,
  input  logic          rx_done,
  output logic [AW-1:0] rx_buf,
  output logic          rx_discard,
  output logic          agent_grant,
  output logic [AW-1:0] agent_buf,
  output logic          irq_empty,
  output logic          tog_flag,
  output logic          mr_valid,
  input  logic          mr_ready,
  output logic [AW-1:0] mr_addr,
  input  logic          mrsp_valid,
  input  logic [AW-1:0] mrsp_data,
  output logic          mw_valid,
  input  logic          mw_ready,
  output logic [AW-1:0] mw_addr,
  output logic [DW-1:0] mw_data
);
  import rcq_pkg::*;

  localparam logic [AW-1:0] LKO = AW'(LINK_OFS);

  logic [AW-1:0] collect, head, tail;
  logic          pending;
  logic          c_busy;
  logic [AW-1:0] c_addr;
  logic          empty;
  logic [DW-3:0] frame_cnt;
  logic          h_req, h_rsp, c_rsp;
  logic [AW-1:0] h_addr;
  logic          head_load;
  logic [AW-1:0] head_next;
  logic          tog_set;
  logic          adv_rd, cmd_agent;

  assign empty     = (head == tail);
  assign adv_rd    = reg_rd && reg_adv && (reg_addr == RA_COLLECT);
  assign cmd_agent = reg_wr && (reg_addr == RA_CTRL) && reg_wdata[CMD_AGENT];

  rcq_stamp #(.DW(DW), .FRAME(FRAME)) u_stamp (
    .clk(clk), .rst_n(rst_n), .frame_cnt(frame_cnt)
  );

  rcq_arb #(.AW(AW)) u_arb (
    .clk(clk), .rst_n(rst_n),
    .h_req(h_req), .h_addr(h_addr),
    .c_req(c_busy), .c_addr(c_addr),
    .mr_valid(mr_valid), .mr_ready(mr_ready), .mr_addr(mr_addr),
    .mrsp_valid(mrsp_valid),
    .h_rsp(h_rsp), .c_rsp(c_rsp)
  );

  rcq_fill #(.AW(AW), .DW(DW), .TS_OFS(TS_OFS), .LINK_OFS(LINK_OFS)) u_fill (
    .clk(clk), .rst_n(rst_n),
    .head(head), .empty(empty), .pending(pending), .frame_cnt(frame_cnt),
    .rx_start_valid(rx_start_valid), .rx_start_ready(rx_start_ready),
    .rx_done(rx_done), .rx_discard(rx_discard),
    .mw_valid(mw_valid), .mw_ready(mw_ready), .mw_addr(mw_addr), .mw_data(mw_data),
    .h_req(h_req), .h_addr(h_addr), .h_rsp(h_rsp), .rsp_ptr(mrsp_data),
    .head_load(head_load), .head_next(head_next),
    .agent_grant(agent_grant), .agent_buf(agent_buf),
    .tog_set(tog_set)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      collect  <= '0;
      head     <= '0;
      tail     <= '0;
      pending  <= 1'b0;
      c_busy   <= 1'b0;
      c_addr   <= '0;
      tog_flag <= 1'b0;
    end else begin
      if (reg_wr && reg_addr == RA_COLLECT) collect <= reg_wdata;
      else if (c_rsp)                       collect <= mrsp_data;

      if (c_rsp) c_busy <= 1'b0;
      else if (adv_rd && !c_busy && collect != head) begin
        c_busy <= 1'b1;
        c_addr <= collect + LKO;
      end

      if (reg_wr && reg_addr == RA_HEAD) head <= reg_wdata;
      else if (head_load)                head <= head_next;

      if (reg_wr && reg_addr == RA_TAIL) tail <= reg_wdata;

      if (agent_grant)    pending <= 1'b0;
      else if (cmd_agent) pending <= 1'b1;

      if (tog_set)                                  tog_flag <= 1'b1;
      else if (reg_rd && reg_addr == RA_CTRL)       tog_flag <= 1'b0;
    end
  end

  always_comb begin
    case (reg_addr)
      RA_COLLECT: reg_rdata = collect;
      RA_HEAD:    reg_rdata = head;
      RA_TAIL:    reg_rdata = tail;
      default:    reg_rdata = {{(AW-3){1'b0}}, pending, empty, tog_flag};
    endcase
  end

  assign rx_buf    = head;
  assign irq_empty = empty;

  a_r3_collect_holds: assert property (@(posedge clk) disable iff (!rst_n)
    adv_rd && !reg_wr && !c_busy && (collect == head) |=> $stable(collect));
  a_r7_tog_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    tog_set |=> tog_flag);
endmodule

// File: tb/rcq_mgr_test.sv
module rcq_mgr_test;
  localparam int AW = 8;
  localparam int DW = 16;
  localparam int FRAME = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic          reg_wr = 0, reg_rd = 0, reg_adv = 0;
  logic [1:0]    reg_addr = 0;
  logic [AW-1:0] reg_wdata = 0;
  logic [AW-1:0] reg_rdata;
  logic          rx_start_valid = 0, rx_start_ready, rx_done = 0;
  logic [AW-1:0] rx_buf;
  logic          rx_discard, agent_grant, irq_empty, tog_flag;
  logic [AW-1:0] agent_buf;
  logic          mr_valid, mr_ready;
  logic [AW-1:0] mr_addr;
  logic          mrsp_valid = 0;
  logic [AW-1:0] mrsp_data = 0;
  logic          mw_valid, mw_ready;
  logic [AW-1:0] mw_addr;
  logic [DW-1:0] mw_data;

  rcq_mgr #(.AW(AW), .DW(DW), .FRAME(FRAME)) uut (
    .clk(clk), .rst_n(rst_n),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_adv(reg_adv), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .rx_start_valid(rx_start_valid), .rx_start_ready(rx_start_ready),
    .rx_done(rx_done), .rx_buf(rx_buf), .rx_discard(rx_discard),
    .agent_grant(agent_grant), .agent_buf(agent_buf),
    .irq_empty(irq_empty), .tog_flag(tog_flag),
    .mr_valid(mr_valid), .mr_ready(mr_ready), .mr_addr(mr_addr),
    .mrsp_valid(mrsp_valid), .mrsp_data(mrsp_data),
    .mw_valid(mw_valid), .mw_ready(mw_ready), .mw_addr(mw_addr), .mw_data(mw_data)
  );

  int checks = 0, errors = 0;
  int cyc = 0;
  int wd = 0;
  int wr_mode = 0;
  logic [AW-1:0] mem [256];
  logic          rd_pend = 0;
  int            rd_cnt = 0;
  logic [AW-1:0] rd_a = 0;
  logic [AW-1:0] rlog [64];
  int            rcount = 0;
  logic [AW-1:0] wlog_addr = 0;
  logic [DW-1:0] wlog_data = 0;
  int            wcount = 0;
  int            done_ts = 0;
  int            gcount = 0;
  logic [AW-1:0] gbuf = 0;
  int            overlap = 0;

  assign mr_ready = cyc[0] | cyc[1];
  assign mw_ready = (wr_mode == 1) ? 1'b0 : (wr_mode == 2) ? 1'b1 : cyc[1];

  always @(posedge clk) begin
    if (!rst_n) cyc <= 0; else cyc <= cyc + 1;
    if (rx_done) done_ts <= cyc / FRAME;
    if (mr_valid && mr_ready) begin
      if (rd_pend || mrsp_valid) overlap <= overlap + 1;
      rd_pend <= 1; rd_cnt <= 2; rd_a <= mr_addr;
      rlog[rcount % 64] <= mr_addr; rcount <= rcount + 1;
    end else if (rd_pend && rd_cnt == 0) begin
      rd_pend <= 0;
    end else if (rd_pend) begin
      rd_cnt <= rd_cnt - 1;
    end
    mrsp_valid <= rd_pend && rd_cnt == 0;
    mrsp_data  <= mem[rd_a];
    if (mw_valid && mw_ready) begin
      wlog_addr <= mw_addr; wlog_data <= mw_data; wcount <= wcount + 1;
    end
    if (agent_grant) begin gcount <= gcount + 1; gbuf <= agent_buf; end
  end

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    wd <= wd + 1;
    if (wd > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input int d);
    @(negedge clk);
    reg_wr = 1; reg_addr = a; reg_wdata = AW'(d);
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd(input logic [1:0] a, input bit adv, output int v);
    @(negedge clk);
    reg_rd = 1; reg_adv = adv; reg_addr = a;
    #1 v = int'(reg_rdata);
    @(negedge clk);
    reg_rd = 0; reg_adv = 0;
  endtask

  task automatic cell_start();
    int n = 0;
    @(negedge clk);
    while (!rx_start_ready && n < 500) begin @(negedge clk); n++; end
    rx_start_valid = 1;
    @(negedge clk);
    rx_start_valid = 0;
  endtask

  task automatic cell_finish();
    repeat (2) @(negedge clk);
    rx_done = 1;
    @(negedge clk);
    rx_done = 0;
  endtask

  task automatic wait_idle();
    int n = 0;
    @(negedge clk);
    while (!(rx_start_ready && !mw_valid && !mr_valid && !rd_pend && !mrsp_valid) && n < 500) begin
      @(negedge clk); n++;
    end
    repeat (12) @(negedge clk);
  endtask

  initial begin
    int v, h, hold_a, rc0, wc0;
    for (int p = 0; p < 256; p++) mem[p] = '0;
    for (int p = 0; p < 64; p += 4) mem[p + 1] = AW'((p + 4) & 63);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    rd(0, 0, v); check(v == 0, "R1 collect", v, 0);
    rd(1, 0, v); check(v == 0, "R1 head", v, 0);
    rd(2, 0, v); check(v == 0, "R1 tail", v, 0);
    check(irq_empty == 1, "R1 irq_empty", irq_empty, 1);
    check(rx_start_ready == 1, "R1 rx_start_ready", rx_start_ready, 1);
    check(!mr_valid && !mw_valid, "R1 mem idle", mr_valid | mw_valid, 0);
    rd(3, 0, v); check(v == 2, "R1 status", v, 2);

    // R2 pointer writes
    wr(0, 8'h20); wr(1, 8'h08); wr(2, 8'h30);
    rd(0, 0, v); check(v == 8'h20, "R2 collect", v, 8'h20);
    rd(1, 0, v); check(v == 8'h08, "R2 head", v, 8'h08);
    rd(2, 0, v); check(v == 8'h30, "R2 tail", v, 8'h30);
    check(irq_empty == 0, "R6 not empty", irq_empty, 0);

    // R4 R5 R6 R7 R8 sweep over free-queue depths
    for (int n = 1; n <= 6; n += (n == 1) ? 2 : 3) begin
      wr(1, 0); wr(2, 4 * n); wr(0, 0);
      for (int k = 0; k < n; k++) begin
        h = 4 * k;
        check(irq_empty == 0, "R6 has free", irq_empty, 0);
        cell_start();
        check(rx_discard == 0, "R4 not discarded", rx_discard, 0);
        cell_finish();
        wait_idle();
        check(wlog_addr == AW'(h), "R4 stamp addr", wlog_addr, h);
        check(rlog[(rcount - 1) % 64] == AW'(h + 1), "R4 link addr", rlog[(rcount - 1) % 64], h + 1);
        rd(1, 0, v); check(v == h + 4, "R4 head advance", v, h + 4);
        check(wlog_data[15] == 1 && wlog_data[14] == 0, "R5 marker/source", wlog_data[15:14], 2);
        check(int'(wlog_data[13:0]) == (done_ts & 16'h3fff), "R5 frame count", wlog_data[13:0], done_ts);
      end
      check(irq_empty == 1, "R6 empty", irq_empty, 1);
      wc0 = wcount; rc0 = rcount;
      cell_start();
      check(rx_discard == 1, "R7 discard", rx_discard, 1);
      check(tog_flag == 1, "R7 tog set", tog_flag, 1);
      cell_finish();
      wait_idle();
      check(wcount == wc0 && rcount == rc0, "R7 no memory access", wcount - wc0 + rcount - rc0, 0);
      rd(1, 0, v); check(v == 4 * n, "R7 head kept", v, 4 * n);
      rd(3, 0, v); check((v & 1) == 1, "R8 status tog", v & 1, 1);
      check((v & 2) == 2, "R8 status empty", v & 2, 2);
      rd(3, 0, v); check((v & 1) == 0, "R8 tog cleared", v & 1, 0);
    end

    // R3 collect advance
    wr(2, 40); wr(1, 12); wr(0, 0);
    rd(0, 1, v); check(v == 0, "R3 adv returns current", v, 0);
    wait_idle();
    rd(0, 0, v); check(v == 4, "R3 collect stepped", v, 4);
    wr(0, 12);
    rd(0, 1, v); wait_idle();
    rd(0, 0, v); check(v == 12, "R3 collect stays at head", v, 12);

    // R9 R10 agent request while empty, then served
    wr(1, 0); wr(2, 0);
    wr(3, 1);
    repeat (3) @(negedge clk);
    rd(3, 0, v); check((v & 4) == 4, "R9 pending visible", v & 4, 4);
    check(rx_start_ready == 1, "R10 ready while empty+pending", rx_start_ready, 1);
    check(gcount == 0, "R10 not served when empty", gcount, 0);
    wr(2, 16);
    wait_idle();
    check(gcount == 1, "R9 one grant", gcount, 1);
    check(gbuf == 0, "R9 grant buffer", gbuf, 0);
    check(wlog_data[14] == 1, "R5 agent source", wlog_data[14], 1);
    rd(1, 0, v); check(v == 4, "R9 head advance", v, 4);
    rd(3, 0, v); check((v & 4) == 0, "R9 pending cleared", v & 4, 0);

    // R9 R10 request during a cell; duplicate ignored
    cell_start();
    wr(3, 1); wr(3, 1);
    rd(3, 0, v); check((v & 4) == 4, "R9 pending during cell", v & 4, 4);
    check(rx_start_ready == 0, "R10 ready low while busy", rx_start_ready, 0);
    cell_finish();
    wait_idle();
    check(gcount == 2, "R9 duplicate ignored", gcount, 2);
    check(gbuf == 8, "R9 agent after cell", gbuf, 8);
    rd(1, 0, v); check(v == 12, "R9 head after both", v, 12);

    // R11 write hold, R12 head fetch priority
    wr(1, 20); wr(2, 40); wr(0, 0);
    wr_mode = 1;
    cell_start(); cell_finish();
    while (!mw_valid) @(negedge clk);
    hold_a = int'(mw_addr);
    @(negedge clk);
    check(mw_valid && int'(mw_addr) == hold_a, "R11 write held", mw_addr, hold_a);
    rc0 = rcount;
    @(negedge clk);
    wr_mode = 2; reg_rd = 1; reg_adv = 1; reg_addr = 0;
    @(negedge clk);
    reg_rd = 0; reg_adv = 0; wr_mode = 0;
    wait_idle(); repeat (20) @(negedge clk);
    check(rlog[rc0 % 64] == 21, "R12 head fetch first", rlog[rc0 % 64], 21);
    check(rlog[(rc0 + 1) % 64] == 1, "R12 collect fetch second", rlog[(rc0 + 1) % 64], 1);
    rd(1, 0, v); check(v == 24, "R12 head result", v, 24);
    rd(0, 0, v); check(v == 4, "R12 collect result", v, 4);
    check(overlap == 0, "R11 single outstanding read", overlap, 0);

    summary();
  end
endmodule